// File: doc/BRIEF.md
# Descriptor Command Sequencer

The sequencer runs a chained program of 16-byte command descriptors held in memory, one channel at a time. When the channel is both running and active, it reads the descriptor at the command pointer, decodes the opcode and the key, and then performs one of four actions. It can hand a block transfer to an external transfer engine. It can move a 1, 2 or 4 byte word between memory and the descriptor's dependent field. It can do nothing for a no-op, or it can halt. After the action it writes the status, and for block transfers the residual count, back into the descriptor in place. It then chooses either the next sequential descriptor or the branch target.

Each descriptor is four little-endian 32-bit words:

| Word | Byte offset | Contents |
|------|-------------|----------|
| 0 | 0 | Request count in bits 15:0, command in bits 31:16 |
| 1 | 4 | Data address |
| 2 | 8 | Dependent address or data |
| 3 | 12 | Residual count in bits 15:0, transfer status in bits 31:16 |

Inside the command field, the opcode sits in bits 15:12 and the key in bits 10:8. The opcode values are:

| Opcode | Action |
|--------|--------|
| 0 | Output, more to follow |
| 1 | Output, last |
| 2 | Input, more to follow |
| 3 | Input, last |
| 4 | Word store |
| 5 | Word load |
| 6 | No-op |
| 7 | Stop |

The status register itself is held outside the block. The sequencer reports its effects on that register as one-cycle pulses: clear wake, clear flush, stop (which clears active), and kill (which sets dead and clears active). Branch and interrupt conditions come from an external condition evaluator. The evaluator reads the current command on `cmd_o`.

Top module: `desc_sequencer`

## Requirements
- R1: Nothing is fetched unless `run_i` and `active_i` are both high. A fetch starts with a one-cycle `wake_clr_o` pulse, followed by four word reads at pointer +0, +4, +8 and +12.
- R2: A stop opcode (7) pulses `stop_o`. It writes nothing to memory and leaves `cmd_ptr_o` unchanged.
- R3: Each of the following pulses `kill_o` and `irq_o` together, writes nothing and leaves the pointer unchanged:
  - an opcode above 7;
  - key 4 on any opcode except no-op and stop;
  - a transfer (opcodes 0 to 3) whose key is above `MAX_STREAM_KEY`;
  - a transfer whose data address is zero;
  - a word load or store whose key is not 0.
- R4: A legal transfer pulses `xfer_start_o` with the following fields:
  - the data address and the request count;
  - `xfer_out_o` high for opcodes 0 and 1;
  - `xfer_last_o` high for opcodes 1 and 3.
- R5: When a transfer completes, word 3 of the descriptor is written with all four byte enables. The written value is `{status_i, residual}`, where the residual is the `xfer_resid_i` value captured at `xfer_done_i`.
- R6: A word load or store uses only request-count bits 2:0:
  - bit 2 set selects 4 bytes, aligned to 4;
  - otherwise bit 1 set selects 2 bytes, aligned to 2;
  - otherwise 1 byte.
  Bytes map to lanes little-endian.
- R7: A word load reads the aligned memory word and replaces the low bytes of the dependent field with the selected bytes. It then writes the dependent field to word 2 with all four byte enables.
- R8: A word store writes the low bytes of the dependent field into the addressed lanes, enabling only those lanes.
- R9: A no-op, a word load and a word store each write the status into the upper half of word 3 only (byte enables 1100).
- R10: After write-back, `flush_clr_o` pulses when the command was a "last" transfer (opcode 1 or 3) or a word load or store.
- R11: Transfers and no-ops branch when `br_cond_i` is high: the pointer becomes the dependent field with its low 4 bits cleared, and `br_taken_o` goes to 1. Otherwise the pointer advances by 16 and `br_taken_o` goes to 0. Word loads and stores always advance.
- R12: After write-back, `irq_o` pulses for one cycle when `irq_cond_i` is high.
- R13: A memory request holds its address and direction until it is acknowledged.
- R14: `ptr_wr_i` loads the pointer (low 4 bits cleared) only while `active_i` is low. While `active_i` is high, `ptr_wr_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Run status bit |
| active_i | input | 1 | Active status bit |
| status_i | input | 16 | Status value written back into descriptors |
| ptr_wr_i | input | 1 | Command pointer load strobe |
| ptr_wdata_i | input | 32 | Command pointer load value |
| cmd_ptr_o | output | 32 | Current command pointer |
| br_taken_o | output | 1 | Last pointer update was a branch |
| cmd_o | output | 16 | Command field of the current descriptor |
| br_cond_i | input | 1 | Branch condition from the evaluator |
| irq_cond_i | input | 1 | Interrupt condition from the evaluator |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | 32 | Memory word address |
| mem_be_o | output | 4 | Memory byte enables |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data |
| mem_ack_i | input | 1 | Memory acknowledge |
| xfer_start_o | output | 1 | Transfer start pulse |
| xfer_addr_o | output | 32 | Transfer address |
| xfer_len_o | output | 16 | Transfer length |
| xfer_out_o | output | 1 | Transfer direction, 1 = to device |
| xfer_last_o | output | 1 | Transfer is the last of a packet |
| xfer_done_i | input | 1 | Transfer completion pulse |
| xfer_resid_i | input | 16 | Residual count at completion |
| wake_clr_o | output | 1 | Clear the wake status bit |
| flush_clr_o | output | 1 | Clear the flush status bit |
| stop_o | output | 1 | Clear the active status bit |
| kill_o | output | 1 | Set dead and clear active |
| irq_o | output | 1 | Interrupt pulse |

## Verification
The bench uses the default parameter values: `MAX_STREAM_KEY` of 3 and `BAD_KEY` of 4. With these values, key 4 and key 5 take different kill paths: one is the illegal key, the other is above the stream limit. A single program can therefore drive both the general-key rejection and the transfer-only rejection. The request counts are chosen to cover every size and alignment case: 3, 5, 0, 1, 6 and 2. These include values with stray bits set, so the priority among request-count bits 2:0 is exercised.

// File: rtl/desc_sequencer.sv
module desc_sequencer #(
  parameter int MAX_STREAM_KEY = 3,
  parameter int BAD_KEY        = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run_i,
  input  logic        active_i,
  input  logic [15:0] status_i,
  input  logic        ptr_wr_i,
  input  logic [31:0] ptr_wdata_i,
  output logic [31:0] cmd_ptr_o,
  output logic        br_taken_o,
  output logic [15:0] cmd_o,
  input  logic        br_cond_i,
  input  logic        irq_cond_i,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [31:0] mem_addr_o,
  output logic [3:0]  mem_be_o,
  output logic [31:0] mem_wdata_o,
  input  logic [31:0] mem_rdata_i,
  input  logic        mem_ack_i,
  output logic        xfer_start_o,
  output logic [31:0] xfer_addr_o,
  output logic [15:0] xfer_len_o,
  output logic        xfer_out_o,
  output logic        xfer_last_o,
  input  logic        xfer_done_i,
  input  logic [15:0] xfer_resid_i,
  output logic        wake_clr_o,
  output logic        flush_clr_o,
  output logic        stop_o,
  output logic        kill_o,
  output logic        irq_o
);

  localparam logic [2:0] K_MAX = 3'(MAX_STREAM_KEY);
  localparam logic [2:0] K_BAD = 3'(BAD_KEY);
  localparam logic [3:0] OP_STORE = 4'd4;
  localparam logic [3:0] OP_LOAD  = 4'd5;
  localparam logic [3:0] OP_NOP   = 4'd6;
  localparam logic [3:0] OP_STOP  = 4'd7;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_DEC, S_XFER, S_WRD, S_WWR, S_WBD, S_WBS, S_NEXT
  } st_t;

  st_t         st;
  logic [31:0] ptr, daddr, dep;
  logic [15:0] reqc, cmd, resid;
  logic [1:0]  widx;
  logic        bt;

  wire [3:0] op      = cmd[15:12];
  wire [2:0] key     = cmd[10:8];
  wire       is_data = op < 4'd4;
  wire       is_word = (op == OP_STORE) || (op == OP_LOAD);
  wire       is_nop  = op == OP_NOP;
  wire       is_stop = op == OP_STOP;

  wire kill_c = (op > OP_STOP)
              || (!is_nop && !is_stop && key == K_BAD)
              || (is_data && (key > K_MAX || daddr == 32'd0))
              || (is_word && key != 3'd0);

  wire sz4 = reqc[2];
  wire sz2 = !reqc[2] && reqc[1];
  wire [31:0] waddr = {daddr[31:2], 2'b00};
  wire [3:0]  w_be  = sz4 ? 4'hF : sz2 ? (daddr[1] ? 4'hC : 4'h3) : (4'b0001 << daddr[1:0]);
  wire [31:0] w_st  = sz4 ? dep : sz2 ? {2{dep[15:0]}} : {4{dep[7:0]}};
  wire [31:0] rd_sh = mem_rdata_i >> {daddr[1:0], 3'b000};
  wire [15:0] rd_hf = daddr[1] ? mem_rdata_i[31:16] : mem_rdata_i[15:0];
  wire [31:0] w_ld  = sz4 ? mem_rdata_i : sz2 ? {dep[31:16], rd_hf} : {dep[31:8], rd_sh[7:0]};

  wire take_br = (is_data || is_nop) && br_cond_i;

  assign cmd_ptr_o    = ptr;
  assign br_taken_o   = bt;
  assign cmd_o        = cmd;
  assign xfer_addr_o  = daddr;
  assign xfer_len_o   = reqc;
  assign xfer_out_o   = !op[1];
  assign xfer_last_o  = op[0];
  assign wake_clr_o   = (st == S_IDLE) && run_i && active_i;
  assign xfer_start_o = (st == S_DEC) && is_data && !kill_c;
  assign stop_o       = (st == S_DEC) && is_stop;
  assign kill_o       = (st == S_DEC) && kill_c;
  assign irq_o        = kill_o || ((st == S_NEXT) && irq_cond_i);
  assign flush_clr_o  = (st == S_NEXT) && ((is_data && op[0]) || is_word);

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = 32'd0;
    mem_be_o    = 4'hF;
    mem_wdata_o = 32'd0;
    case (st)
      S_FETCH: begin
        mem_req_o  = 1'b1;
        mem_addr_o = ptr + {28'd0, widx, 2'b00};
      end
      S_WRD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = waddr;
      end
      S_WWR: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = waddr;
        mem_be_o    = w_be;
        mem_wdata_o = w_st;
      end
      S_WBD: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = ptr + 32'd8;
        mem_wdata_o = dep;
      end
      S_WBS: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = ptr + 32'd12;
        mem_be_o    = is_data ? 4'hF : 4'hC;
        mem_wdata_o = {status_i, resid};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      ptr   <= 32'd0;
      bt    <= 1'b0;
      widx  <= 2'd0;
      reqc  <= 16'd0;
      cmd   <= 16'd0;
      daddr <= 32'd0;
      dep   <= 32'd0;
      resid <= 16'd0;
    end else begin
      if (ptr_wr_i && !active_i) ptr <= ptr_wdata_i & ~32'hF;
      case (st)
        S_IDLE: if (run_i && active_i) begin
          st   <= S_FETCH;
          widx <= 2'd0;
        end
        S_FETCH: if (mem_ack_i) begin
          case (widx)
            2'd0: begin reqc <= mem_rdata_i[15:0]; cmd <= mem_rdata_i[31:16]; end
            2'd1: daddr <= mem_rdata_i;
            2'd2: dep   <= mem_rdata_i;
            default: ;
          endcase
          widx <= widx + 2'd1;
          if (widx == 2'd3) st <= S_DEC;
        end
        S_DEC: begin
          if (kill_c || is_stop) st <= S_IDLE;
          else if (is_data)      st <= S_XFER;
          else if (is_nop)       st <= S_WBS;
          else if (op == OP_STORE) st <= S_WWR;
          else                   st <= S_WRD;
        end
        S_XFER: if (xfer_done_i) begin
          resid <= xfer_resid_i;
          st    <= S_WBS;
        end
        S_WRD: if (mem_ack_i) begin
          dep <= w_ld;
          st  <= S_WBD;
        end
        S_WWR: if (mem_ack_i) st <= S_WBS;
        S_WBD: if (mem_ack_i) st <= S_WBS;
        S_WBS: if (mem_ack_i) st <= S_NEXT;
        S_NEXT: begin
          if (take_br) begin
            ptr <= dep & ~32'hF;
            bt  <= 1'b1;
          end else begin
            ptr <= ptr + 32'd16;
            bt  <= 1'b0;
          end
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/desc_sequencer_chk.sv
module desc_sequencer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic [31:0] mem_addr_o,
  input logic        mem_ack_i,
  input logic        wake_clr_o,
  input logic        stop_o,
  input logic        kill_o,
  input logic        irq_o,
  input logic        xfer_start_o,
  input logic [31:0] xfer_addr_o,
  input logic [31:0] cmd_ptr_o
);

  p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  p_fetch_follows_wake_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wake_clr_o |=> mem_req_o && !mem_we_o);

  p_stop_holds_ptr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |=> $stable(cmd_ptr_o));

  p_kill_raises_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    kill_o |-> irq_o && !xfer_start_o && !mem_req_o);

  p_start_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start_o |-> xfer_addr_o != 32'd0);

endmodule

bind desc_sequencer desc_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .mem_ack_i(mem_ack_i), .wake_clr_o(wake_clr_o),
  .stop_o(stop_o), .kill_o(kill_o), .irq_o(irq_o), .xfer_start_o(xfer_start_o),
  .xfer_addr_o(xfer_addr_o), .cmd_ptr_o(cmd_ptr_o)
);

// File: tb/desc_sequencer_test.sv
module desc_sequencer_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, run_i, active, go, ptr_wr, br_c, irq_c, ack, done;
  logic [31:0] ptr_wd, rdata;
  logic [15:0] resid_in, xlen;
  logic [2:0]  xcnt;
  logic [31:0] cmd_ptr, m_addr, m_wd, x_addr;
  logic [15:0] cmd, x_len;
  logic [3:0]  m_be;
  logic bt, m_req, m_we, x_start, x_out, x_last, wake, flush, stp, kill, irq;
  localparam logic [15:0] STAT = 16'h9C05;

  desc_sequencer uut (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .active_i(active), .status_i(STAT),
    .ptr_wr_i(ptr_wr), .ptr_wdata_i(ptr_wd), .cmd_ptr_o(cmd_ptr), .br_taken_o(bt),
    .cmd_o(cmd), .br_cond_i(br_c), .irq_cond_i(irq_c), .mem_req_o(m_req),
    .mem_we_o(m_we), .mem_addr_o(m_addr), .mem_be_o(m_be), .mem_wdata_o(m_wd),
    .mem_rdata_i(rdata), .mem_ack_i(ack), .xfer_start_o(x_start), .xfer_addr_o(x_addr),
    .xfer_len_o(x_len), .xfer_out_o(x_out), .xfer_last_o(x_last), .xfer_done_i(done),
    .xfer_resid_i(resid_in), .wake_clr_o(wake), .flush_clr_o(flush), .stop_o(stp),
    .kill_o(kill), .irq_o(irq));

  logic [31:0] mem [0:255];
  int checks = 0, fails = 0, wakes = 0, reqs = 0, cyc = 0;

  typedef struct { int k; logic [31:0] a; logic [31:0] d; logic [3:0] be; string r; } ev_t;
  ev_t q[$];

  always @(posedge clk) begin
    if (!rst_n) ack <= 1'b0;
    else if (m_req && !ack) begin
      ack   <= 1'b1;
      rdata <= mem[m_addr[9:2]];
      if (m_we)
        for (int b = 0; b < 4; b++)
          if (m_be[b]) mem[m_addr[9:2]][8*b +: 8] <= m_wd[8*b +: 8];
    end else ack <= 1'b0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin xcnt <= 3'd0; done <= 1'b0; end
    else begin
      done <= 1'b0;
      if (x_start) begin xcnt <= 3'd4; xlen <= x_len; end
      else if (xcnt != 3'd0) begin
        xcnt <= xcnt - 3'd1;
        if (xcnt == 3'd1) begin done <= 1'b1; resid_in <= xlen >> 1; end
      end
    end
  end

  always @(posedge clk) begin
    if (!rst_n) active <= 1'b0;
    else if (go) active <= 1'b1;
    else if (kill || stp) active <= 1'b0;
  end

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%h expected=%h", r, act, exp); end
  endtask

  task automatic ex(input int k, input logic [31:0] a, input logic [31:0] d, input logic [3:0] be, input string r);
    ev_t e;
    e.k = k; e.a = a; e.d = d; e.be = be; e.r = r;
    q.push_back(e);
  endtask

  task automatic see(input int k, input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
    ev_t e;
    logic [31:0] m;
    checks++;
    if (q.size() == 0) begin
      fails++;
      $display("FAIL event-order unexpected kind=%0d addr=%h data=%h be=%h expected none", k, a, d, be);
      return;
    end
    e = q.pop_front();
    m = (k == 2) ? {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}} : 32'hFFFFFFFF;
    if (e.k != k || e.a != a || (e.d & m) != (d & m) || e.be != be) begin
      fails++;
      $display("FAIL %s actual kind=%0d addr=%h data=%h be=%h expected kind=%0d addr=%h data=%h be=%h",
               e.r, k, a, d & m, be, e.k, e.a, e.d & m, e.be);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (x_start) see(1, x_addr, {14'd0, x_out, x_last, x_len}, 4'hF);
    if (m_req && m_we && ack) see(2, m_addr, m_wd, m_be);
    if (kill)  see(3, 0, 0, 4'h0);
    if (stp)   see(4, 0, 0, 4'h0);
    if (flush) see(6, 0, 0, 4'h0);
    if (irq)   see(5, 0, 0, 4'h0);
    if (wake)  wakes++;
    if (m_req) reqs++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic logic [15:0] cw(input logic [3:0] op, input logic [2:0] key);
    return {op, 1'b0, key, 8'h00};
  endfunction

  task automatic put_desc(input logic [31:0] a, input logic [3:0] op, input logic [2:0] key,
                          input logic [15:0] rq, input logic [31:0] da, input logic [31:0] dp);
    mem[a[9:2]]        = {cw(op, key), rq};
    mem[a[9:2] + 8'd1] = da;
    mem[a[9:2] + 8'd2] = dp;
    mem[a[9:2] + 8'd3] = 32'hFFFFFFFF;
  endtask

  task automatic start_at(input logic [31:0] p);
    @(negedge clk); ptr_wr = 1'b1; ptr_wd = p;
    @(negedge clk); ptr_wr = 1'b0; go = 1'b1;
    @(negedge clk); go = 1'b0;
  endtask

  task automatic finish_prog(input string r);
    while (active) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(q.size() == 0, r, q.size(), 0);
  endtask

  task automatic kill_case(input logic [31:0] a, input logic [3:0] op, input logic [2:0] key,
                           input logic [31:0] da);
    put_desc(a, op, key, 16'h0004, da, 32'h0);
    ex(3, 0, 0, 4'h0, "R3 kill"); ex(5, 0, 0, 4'h0, "R3 kill irq");
    start_at(a);
    finish_prog("R3 kill events");
    chk(cmd_ptr == a, "R3 pointer kept", cmd_ptr, a);
    chk(mem[a[9:2] + 8'd3] == 32'hFFFFFFFF, "R3 no write-back", mem[a[9:2] + 8'd3], 32'hFFFFFFFF);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    rst_n = 1'b0; run_i = 1'b0; go = 1'b0; ptr_wr = 1'b0; ptr_wd = 32'h0; br_c = 1'b0; irq_c = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ptr == 32'h0, "reset pointer", cmd_ptr, 0);
    chk(bt == 1'b0, "reset branch flag", bt, 0);
    chk(m_req == 1'b0, "reset memory idle", m_req, 0);
    chk(irq == 1'b0 && x_start == 1'b0, "reset pulses", irq, 0);

    // R1 R4 R5 R2 R14: one output transfer then stop
    put_desc(32'h040, 4'd0, 3'd0, 16'h0030, 32'h200, 32'h0);
    put_desc(32'h050, 4'd7, 3'd0, 16'h0, 32'h0, 32'h0);
    wakes = 0;
    start_at(32'h040);
    reqs = 0;
    repeat (10) @(negedge clk);
    chk(reqs == 0, "R1 no fetch without run", reqs, 0);
    ex(1, 32'h200, {14'd0, 1'b1, 1'b0, 16'h0030}, 4'hF, "R4 output start");
    ex(2, 32'h04C, {STAT, 16'h0018}, 4'hF, "R5 transfer write-back");
    ex(4, 0, 0, 4'h0, "R2 stop");
    run_i = 1'b1;
    while (!x_start) @(negedge clk);
    ptr_wr = 1'b1; ptr_wd = 32'h3F0;
    @(negedge clk); ptr_wr = 1'b0;
    finish_prog("R5 events");
    chk(cmd_ptr == 32'h050, "R2 R14 pointer after stop", cmd_ptr, 32'h050);
    chk(wakes == 2, "R1 wake pulse per fetch", wakes, 2);
    chk(bt == 1'b0, "R11 sequential flag", bt, 0);

    // R11 R10 R12: input-last with branch and interrupt
    br_c = 1'b1; irq_c = 1'b1;
    put_desc(32'h080, 4'd3, 3'd2, 16'h0008, 32'h300, 32'h0A7);
    put_desc(32'h0A0, 4'd7, 3'd0, 16'h0, 32'h0, 32'h0);
    ex(1, 32'h300, {14'd0, 1'b0, 1'b1, 16'h0008}, 4'hF, "R4 input-last start");
    ex(2, 32'h08C, {STAT, 16'h0004}, 4'hF, "R5 input write-back");
    ex(6, 0, 0, 4'h0, "R10 flush on last");
    ex(5, 0, 0, 4'h0, "R12 completion irq");
    ex(4, 0, 0, 4'h0, "R2 stop");
    start_at(32'h080);
    finish_prog("R11 events");
    chk(cmd_ptr == 32'h0A0, "R11 branch target", cmd_ptr, 32'h0A0);
    chk(bt == 1'b1, "R11 branch flag", bt, 1);

    // R6 R7 R9 R11: word loads never branch
    irq_c = 1'b0;
    mem[8'h80] = 32'hDEADBEEF;
    mem[8'h81] = 32'hCAFEF00D;
    put_desc(32'h0C0, 4'd5, 3'd0, 16'h0003, 32'h203, 32'h11223344);
    put_desc(32'h0D0, 4'd5, 3'd0, 16'h0005, 32'h207, 32'h0);
    put_desc(32'h0E0, 4'd5, 3'd0, 16'h0000, 32'h206, 32'hAABBCCDD);
    put_desc(32'h0F0, 4'd7, 3'd0, 16'h0, 32'h0, 32'h0);
    ex(2, 32'h0C8, 32'h1122DEAD, 4'hF, "R7 R6 half load");
    ex(2, 32'h0CC, {STAT, 16'h0}, 4'hC, "R9 load status");
    ex(6, 0, 0, 4'h0, "R10 flush on load");
    ex(2, 32'h0D8, 32'hCAFEF00D, 4'hF, "R7 R6 word load");
    ex(2, 32'h0DC, {STAT, 16'h0}, 4'hC, "R9 load status");
    ex(6, 0, 0, 4'h0, "R10 flush on load");
    ex(2, 32'h0E8, 32'hAABBCCFE, 4'hF, "R7 R6 byte load");
    ex(2, 32'h0EC, {STAT, 16'h0}, 4'hC, "R9 load status");
    ex(6, 0, 0, 4'h0, "R10 flush on load");
    ex(4, 0, 0, 4'h0, "R2 stop");
    start_at(32'h0C0);
    finish_prog("R7 events");
    chk(cmd_ptr == 32'h0F0, "R11 word ops advance", cmd_ptr, 32'h0F0);

    // R8 R6 R12: word stores
    br_c = 1'b0; irq_c = 1'b1;
    mem[8'hC0] = 32'h0; mem[8'hC1] = 32'h0;
    put_desc(32'h100, 4'd4, 3'd0, 16'h0001, 32'h301, 32'h12345677);
    put_desc(32'h110, 4'd4, 3'd0, 16'h0006, 32'h307, 32'h89ABCDEF);
    put_desc(32'h120, 4'd4, 3'd0, 16'h0002, 32'h303, 32'h00005566);
    put_desc(32'h130, 4'd7, 3'd0, 16'h0, 32'h0, 32'h0);
    ex(2, 32'h300, 32'h00007700, 4'h2, "R8 R6 byte store");
    ex(2, 32'h10C, {STAT, 16'h0}, 4'hC, "R9 store status");
    ex(6, 0, 0, 4'h0, "R10 flush on store"); ex(5, 0, 0, 4'h0, "R12 store irq");
    ex(2, 32'h304, 32'h89ABCDEF, 4'hF, "R8 R6 word store");
    ex(2, 32'h11C, {STAT, 16'h0}, 4'hC, "R9 store status");
    ex(6, 0, 0, 4'h0, "R10 flush on store"); ex(5, 0, 0, 4'h0, "R12 store irq");
    ex(2, 32'h300, 32'h55660000, 4'hC, "R8 R6 half store");
    ex(2, 32'h12C, {STAT, 16'h0}, 4'hC, "R9 store status");
    ex(6, 0, 0, 4'h0, "R10 flush on store"); ex(5, 0, 0, 4'h0, "R12 store irq");
    ex(4, 0, 0, 4'h0, "R2 stop");
    start_at(32'h100);
    finish_prog("R8 events");
    chk(mem[8'hC0] == 32'h55667700, "R8 merged lanes", mem[8'hC0], 32'h55667700);
    chk(mem[8'hC1] == 32'h89ABCDEF, "R8 full word", mem[8'hC1], 32'h89ABCDEF);

    // R9 R11: no-op without and with branch
    irq_c = 1'b0;
    put_desc(32'h140, 4'd6, 3'd0, 16'h0, 32'h0, 32'h3C0);
    put_desc(32'h150, 4'd7, 3'd0, 16'h0, 32'h0, 32'h0);
    ex(2, 32'h14C, {STAT, 16'h0}, 4'hC, "R9 nop status");
    ex(4, 0, 0, 4'h0, "R2 stop");
    start_at(32'h140);
    finish_prog("R9 events");
    chk(cmd_ptr == 32'h150, "R11 nop advance", cmd_ptr, 32'h150);
    br_c = 1'b1;
    put_desc(32'h160, 4'd6, 3'd0, 16'h0, 32'h0, 32'h180);
    put_desc(32'h180, 4'd7, 3'd0, 16'h0, 32'h0, 32'h0);
    ex(2, 32'h16C, {STAT, 16'h0}, 4'hC, "R9 nop status");
    ex(4, 0, 0, 4'h0, "R2 stop");
    start_at(32'h160);
    finish_prog("R11 nop events");
    chk(cmd_ptr == 32'h180 && bt == 1'b1, "R11 nop branch", cmd_ptr, 32'h180);

    // R3: every kill path
    br_c = 1'b0;
    kill_case(32'h1C0, 4'd0, 3'd0, 32'h0);
    kill_case(32'h1D0, 4'd1, 3'd4, 32'h200);
    kill_case(32'h1E0, 4'd2, 3'd5, 32'h200);
    kill_case(32'h1F0, 4'd5, 3'd1, 32'h200);
    kill_case(32'h240, 4'd9, 3'd0, 32'h200);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule